// File: doc/BRIEF.md
# Serializer Sync Burst Controller

This controller sits in front of a 10-bit serializer and decides, on every reference clock cycle, whether the word handed to the shift register is captured parallel data or a fixed training word. The receiver uses these training words to lock onto the link. Two request inputs may ask for training. Their OR has to stay high for a qualification window before anything happens, so brief glitches do nothing.

Once a request qualifies, the controller sends a burst of training words with a guaranteed minimum length. If the request is still high when that minimum runs out, the burst continues until the request drops. A new burst needs a new, complete qualification hold.

The block also captures the parallel data on a selectable clock edge. It produces an output-enable flag for the line driver and a run flag for the clock multiplier, and a power-down input stops all of its activity.

Top module: `sync_burst_ctrl`

## Requirements
- R1: The combined request is the logical OR of `req_a` and `req_b`. Either input alone, or both together, behaves the same way.
- R2: A burst starts after the combined request has been sampled high on QUAL_CYC (6) consecutive rising edges. `word_is_sync` is first high just after the 6th such edge.
- R3: A combined request that is high for fewer than QUAL_CYC consecutive edges produces no training word. The qualification count restarts from zero whenever the request is low.
- R4: Every burst contains at least MIN_WORDS (1026) training words, that is, `word_is_sync` stays high for at least 1026 cycles, even if the request is already low.
- R5: If the request is still high at the edge that completes the minimum, the burst extends until the first edge at which the request is low. A request held for L ≥ 6 edges therefore gives max(1026, L−5) training words.
- R6: After a burst ends, a new burst needs a new run of QUAL_CYC consecutive high edges, counted from zero.
- R7: While a burst is active, `word_out` is the training word 10'b1111100000 (bits 9..5 one, bits 4..0 zero) and `word_is_sync` is 1. Otherwise `word_out` is the captured data and `word_is_sync` is 0.
- R8: With `edge_sel`=1, the captured data is `data_in` as of the latest rising clock edge. With `edge_sel`=0, it is `data_in` as of the latest falling clock edge.
- R9: `out_en` is high exactly when both `drv_en` and `pwr_on` are high.
- R10: While `pwr_on` is low, `pll_run` and `out_en` are 0, `word_out` is 0 and `word_is_sync` is 0. A power-down edge clears the burst and the qualification count, so a burst does not resume afterwards and qualification restarts from zero.
- R11: A synchronous active-high `rst` clears the burst, the qualification count and the captured data. After reset, `word_out` is 0 and `word_is_sync` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| req_a | input | 1 | Training request, first source |
| req_b | input | 1 | Training request, second source |
| edge_sel | input | 1 | Capture edge: 1 rising, 0 falling |
| data_in | input | 10 | Parallel data to send |
| drv_en | input | 1 | Line driver enable request |
| pwr_on | input | 1 | Low selects power-down |
| word_out | output | 10 | Word for the serializer |
| word_is_sync | output | 1 | Marks `word_out` as a training word |
| out_en | output | 1 | Line driver output enable |
| pll_run | output | 1 | Clock multiplier run qualifier |

## Verification
Several properties are checked on every cycle:
- the burst state never leaves the minimum phase early and always releases on a low request;
- the burst counter stays in range;
- the qualification count clears on a low request;
- the training word value, the enable gating, the clearing at power-down and rising-edge capture all hold.

Only the bench scenarios can show the exact burst lengths. That covers lengths at and just past the extension boundary, the start cycle for each request source, the fact that pulses shorter than the window are ignored, re-qualification after a burst, and falling-edge capture.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    // Width of one serializer word
    localparam int unsigned WORD_W = 10;

    // Burst sequencing phases
    typedef enum logic [1:0] {
        B_IDLE = 2'd0,  // data words flow
        B_MIN  = 2'd1,  // counting toward the minimum burst length
        B_HOLD = 2'd2   // extended while the request stays high
    } burst_st_e;

    // Word handed to the serializer together with its marker
    typedef struct packed {
        logic              is_train;
        logic [WORD_W-1:0] bits;
    } ser_word_t;

    // Training pattern: upper half ones, lower half zeros
    function automatic logic [WORD_W-1:0] train_pattern();
        logic [WORD_W-1:0] w;
        for (int i = 0; i < WORD_W; i++) begin
            w[i] = (i >= WORD_W / 2);
        end
        return w;
    endfunction

endpackage

// File: rtl/sbc_req_qual.sv
module sbc_req_qual #(
    parameter int unsigned QUAL_CYC = 6
) (
    input  logic clk,
    input  logic clr,
    input  logic req,
    input  logic hold_off,
    output logic fire
);
    localparam int unsigned QW = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;
    localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYC - 1);

    logic [QW-1:0] qcnt;

    // Fires on the edge that completes the qualification window
    assign fire = req && !hold_off && (qcnt == Q_LAST);

    always_ff @(posedge clk) begin
        if (clr || hold_off || !req || fire) begin
            qcnt <= '0;
        end else begin
            qcnt <= qcnt + 1'b1;
        end
    end

    // A low request must wipe any partial qualification
    p_short_clear_r3: assert property (@(posedge clk) disable iff (clr)
        !req |=> (qcnt == '0));

    // The count never runs past the window
    p_qual_bound_r2: assert property (@(posedge clk) disable iff (clr)
        qcnt <= Q_LAST);

endmodule

// File: rtl/sbc_burst_ctl.sv
module sbc_burst_ctl
    import sbc_pkg::*;
#(
    parameter int unsigned MIN_WORDS = 1026
) (
    input  logic clk,
    input  logic clr,
    input  logic fire,
    input  logic req,
    output logic active
);
    localparam int unsigned CW = (MIN_WORDS > 2) ? $clog2(MIN_WORDS) : 1;
    localparam logic [CW-1:0] C_LAST = CW'(MIN_WORDS - 1);

    burst_st_e      st;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (clr) begin
            st  <= B_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                B_IDLE: begin
                    if (fire) begin
                        st  <= B_MIN;
                        cnt <= '0;
                    end
                end
                B_MIN: begin
                    if (cnt == C_LAST) begin
                        st  <= req ? B_HOLD : B_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                B_HOLD: begin
                    if (!req) begin
                        st <= B_IDLE;
                    end
                end
                default: st <= B_IDLE;
            endcase
        end
    end

    assign active = (st != B_IDLE);

    // Minimum length: no exit before the last counted word
    p_min_len_r4: assert property (@(posedge clk) disable iff (clr)
        (st == B_MIN && cnt != C_LAST) |=> (st == B_MIN));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (clr)
        cnt <= C_LAST);

    // A held request keeps the burst alive
    p_extend_r5: assert property (@(posedge clk) disable iff (clr)
        (active && req) |=> active);

    // An extended burst ends on the first low request
    p_release_r5: assert property (@(posedge clk) disable iff (clr)
        (st == B_HOLD && !req) |=> (st == B_IDLE));

    // A burst starts only from a qualification pulse
    p_start_r2: assert property (@(posedge clk) disable iff (clr)
        (st == B_IDLE && !fire) |=> (st == B_IDLE));

endmodule

// File: rtl/sbc_capture.sv
module sbc_capture
    import sbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              edge_sel,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    logic [WORD_W-1:0] rise_q;
    logic [WORD_W-1:0] fall_q;

    always_ff @(posedge clk) begin
        if (rst) rise_q <= '0;
        else     rise_q <= d;
    end

    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= d;
    end

    assign q = edge_sel ? rise_q : fall_q;

    // Rising-edge selection presents the value seen at the last rising edge
    p_rise_path_r8: assert property (@(posedge clk) disable iff (rst)
        (edge_sel && !$past(rst)) |-> (q == $past(d)));

endmodule

// File: rtl/sync_burst_ctrl.sv
module sync_burst_ctrl
    import sbc_pkg::*;
#(
    parameter int unsigned QUAL_CYC  = 6,
    parameter int unsigned MIN_WORDS = 1026
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_a,
    input  logic              req_b,
    input  logic              edge_sel,
    input  logic [WORD_W-1:0] data_in,
    input  logic              drv_en,
    input  logic              pwr_on,
    output logic [WORD_W-1:0] word_out,
    output logic              word_is_sync,
    output logic              out_en,
    output logic              pll_run
);
    localparam logic [WORD_W-1:0] TRAIN_W = train_pattern();

    logic              req_any;
    logic              halt;
    logic              fire;
    logic              active;
    logic [WORD_W-1:0] lat;
    ser_word_t         nxt;

    assign req_any = req_a | req_b;
    assign halt    = rst | ~pwr_on;

    sbc_req_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk      (clk),
        .clr      (halt),
        .req      (req_any),
        .hold_off (active),
        .fire     (fire)
    );

    sbc_burst_ctl #(.MIN_WORDS(MIN_WORDS)) u_burst (
        .clk    (clk),
        .clr    (halt),
        .fire   (fire),
        .req    (req_any),
        .active (active)
    );

    sbc_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .edge_sel (edge_sel),
        .d        (data_in),
        .q        (lat)
    );

    always_comb begin
        if (!pwr_on) begin
            nxt = '0;
        end else if (active) begin
            nxt.is_train = 1'b1;
            nxt.bits     = TRAIN_W;
        end else begin
            nxt.is_train = 1'b0;
            nxt.bits     = lat;
        end
    end

    assign word_out     = nxt.bits;
    assign word_is_sync = nxt.is_train;
    assign out_en       = pwr_on & drv_en;
    assign pll_run      = pwr_on;

    // Training words always carry the fixed pattern
    p_train_value_r7: assert property (@(posedge clk) disable iff (rst)
        word_is_sync |-> (word_out == TRAIN_W));

    // A burst can only begin after a high combined request
    p_start_req_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(word_is_sync) |-> $past(req_a || req_b));

    // The driver is never enabled while powered down or disabled
    p_oe_gate_r9: assert property (@(posedge clk) disable iff (rst)
        out_en |-> (pwr_on && drv_en));

    // A power-down edge leaves no burst behind
    p_pd_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !pwr_on |=> !word_is_sync);

endmodule

// File: tb/sync_burst_ctrl_tb.sv
module sync_burst_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL      = 6;
    localparam int MINW      = 1026;
    localparam logic [9:0] TRAIN = 10'b11111_00000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_a = 1'b0;
    logic       req_b = 1'b0;
    logic       edge_sel = 1'b1;
    logic [9:0] data_in = '0;
    logic       drv_en = 1'b1;
    logic       pwr_on = 1'b1;
    logic [9:0] word_out;
    logic       word_is_sync;
    logic       out_en;
    logic       pll_run;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sync_burst_ctrl #(.QUAL_CYC(QUAL), .MIN_WORDS(MINW)) dut_i (
        .clk(clk), .rst(rst), .req_a(req_a), .req_b(req_b),
        .edge_sel(edge_sel), .data_in(data_in), .drv_en(drv_en),
        .pwr_on(pwr_on), .word_out(word_out), .word_is_sync(word_is_sync),
        .out_en(out_en), .pll_run(pll_run)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance one rising edge and land 1 time unit after it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Hold the request for len edges, then measure start edge and burst length
    task automatic run_burst(input int len, input logic ua, input logic ub, input string tag);
        int first = -1;
        int cnt   = 0;
        int limit;
        int exp_len;
        limit = (len < QUAL) ? 20 : ((len > MINW + 10 ? len : MINW + 10) + 20);
        req_a = ua && (len > 0);
        req_b = ub && (len > 0);
        for (int e = 1; e <= limit; e++) begin
            step();
            if (word_is_sync) begin
                cnt++;
                if (first < 0) begin
                    first = e;
                    chk(word_out == TRAIN, {tag, " R7 training value"}, word_out, TRAIN);
                end
            end
            req_a = ua && (e < len);
            req_b = ub && (e < len);
            if (first >= 0 && !word_is_sync) break;
        end
        req_a = 1'b0;
        req_b = 1'b0;
        if (len < QUAL) begin
            chk(cnt == 0, {tag, " R3 short request ignored"}, cnt, 0);
        end else begin
            exp_len = (len - QUAL + 1 > MINW) ? (len - QUAL + 1) : MINW;
            chk(first == QUAL, {tag, " R2 start edge"}, first, QUAL);
            chk(cnt == exp_len, {tag, " R4/R5 burst length"}, cnt, exp_len);
            chk(word_out == data_in && !word_is_sync, {tag, " R7 data after burst"}, word_out, data_in);
        end
        step();
    endtask

    initial begin
        data_in = 10'h155;
        step(); step(); step();
        // R11: reset state
        chk(word_out == 10'd0, "R11 word after reset", word_out, 0);
        chk(word_is_sync == 1'b0, "R11 no training after reset", word_is_sync, 0);
        rst = 1'b0;
        step(); step();
        chk(word_out == 10'h155, "R7 data path idle", word_out, 10'h155);

        // R1/R2/R3/R4/R5: sweep request lengths for each source combination
        for (int src = 0; src < 3; src++) begin
            logic ua;
            logic ub;
            ua = (src != 1);
            ub = (src != 0);
            for (int l = 0; l <= 8; l++) run_burst(l, ua, ub, "R1 sweep");
            run_burst(MINW + QUAL - 1, ua, ub, "R5 boundary");
            run_burst(MINW + QUAL, ua, ub, "R5 one past");
        end
        run_burst(1500, 1'b1, 1'b0, "R5 long hold");

        // R6: after a burst, a short hold does nothing, a full hold qualifies anew
        run_burst(MINW + 40, 1'b0, 1'b1, "R6 first");
        run_burst(QUAL - 1, 1'b1, 1'b0, "R6 short after burst");
        run_burst(QUAL, 1'b1, 1'b0, "R6 fresh hold");

        // R8: capture edge selection
        for (int p = 0; p < 6; p++) begin
            logic [9:0] x;
            logic [9:0] y;
            x = 10'(37 * p + 5);
            y = ~x;
            data_in = x;
            #5;
            data_in = y;
            @(posedge clk);
            #1;
            edge_sel = 1'b1;
            #1;
            chk(word_out == y, "R8 rising capture", word_out, y);
            edge_sel = 1'b0;
            #1;
            chk(word_out == x, "R8 falling capture", word_out, x);
        end
        edge_sel = 1'b1;
        data_in  = 10'h155;
        step();

        // R9: enable gating over all input combinations
        for (int k = 0; k < 4; k++) begin
            drv_en = k[0];
            pwr_on = k[1];
            #1;
            chk(out_en == (k == 3), "R9 output enable", out_en, int'(k == 3));
            chk(pll_run == k[1], "R10 pll run", pll_run, k[1]);
        end
        drv_en = 1'b1;
        pwr_on = 1'b1;
        step();

        // R10: power-down mid-burst clears the burst
        req_a = 1'b1;
        for (int i = 0; i < QUAL; i++) step();
        req_a = 1'b0;
        for (int i = 0; i < 10; i++) step();
        chk(word_is_sync == 1'b1, "R10 burst running", word_is_sync, 1);
        pwr_on = 1'b0;
        #1;
        chk(word_out == 10'd0 && out_en == 1'b0, "R10 outputs off", word_out, 0);
        step();
        pwr_on = 1'b1;
        #1;
        chk(word_is_sync == 1'b0, "R10 burst cleared", word_is_sync, 0);
        for (int i = 0; i < 20; i++) step();
        chk(word_is_sync == 1'b0, "R10 no resume", word_is_sync, 0);

        // R10: power-down restarts the qualification count
        req_b = 1'b1;
        for (int i = 0; i < 4; i++) step();
        pwr_on = 1'b0;
        step();
        pwr_on = 1'b1;
        for (int i = 0; i < QUAL - 1; i++) step();
        chk(word_is_sync == 1'b0, "R10 qualification restarted", word_is_sync, 0);
        step();
        chk(word_is_sync == 1'b1, "R10 qualifies after restart", word_is_sync, 1);
        req_b = 1'b0;

        // R11: reset during a burst
        rst = 1'b1;
        step();
        chk(word_is_sync == 1'b0 && word_out == 10'd0, "R11 reset mid-burst", word_out, 0);
        rst = 1'b0;
        step();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule